// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that answers at one fixed 7-bit address and gives a bus controller access to a small register file. It watches the open-drain clock and data lines through synchronisers. It pulls the data line low only to acknowledge or to return read data. Its `sda_oe_o` output is meant to drive an open-drain pad: when it is 1 the pad pulls low, and when it is 0 the pad is released.

Every transfer opens with a START and an address byte. In a write, the first byte after the address selects a register through an internal pointer, and each later byte is stored at the pointer. A read returns bytes starting at the pointer. The pointer moves forward by one for every data byte moved in either direction. Because the pointer is kept across repeated START and STOP, a write of the pointer followed by a repeated START and a read returns data from the chosen register. Logic next to the block reads and writes the same registers through a plain parallel port.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, `sda_oe_o` is 0, every register reads 0 on the local port, and the pointer is 0.
- R2: After a START, the target drives the acknowledge slot low if bits 7:1 of the first byte (MSB first) equal `DEV_ADDR`. Otherwise it leaves the line released in that slot and in every slot up to the next START or STOP, and it writes no register.
- R3: In a write (address byte bit 0 = 0), the target acknowledges the first data byte and loads the pointer from that byte's low `REG_AW` bits.
- R4: Each later write byte is acknowledged and stored at the pointer, and the pointer then increments modulo 2^`REG_AW`.
- R5: In a read (address byte bit 0 = 1), the target returns the register at the pointer MSB first, and the pointer increments after each byte it loads.
- R6: The pointer keeps its value across repeated START and STOP, so a pointer write followed by a repeated START and a read returns that register.
- R7: When the controller leaves the acknowledge slot after a read byte released (NAK), the target releases SDA and drives nothing until the next START or STOP.
- R8: A STOP returns the target to idle with SDA released, and a byte cut short by a STOP is discarded.
- R9: The target changes `sda_oe_o` only while SCL is low.
- R10: The local port returns register `loc_addr_i` on `loc_rdata_o` in the same cycle, and writes `loc_wdata_i` to that register on a clock edge with `loc_we_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| loc_addr_i | input | REG_AW | Local port register index |
| loc_we_i | input | 1 | Local port write strobe |
| loc_wdata_i | input | 8 | Local port write data |
| loc_rdata_o | output | 8 | Local port read data |

## Verification
The bench builds the block with `DEV_ADDR` = 0x3C and `REG_AW` = 3, which gives eight registers. With eight registers, short random bursts often cross the top of the register file, so pointer wrap is covered in both write and read bursts. A pointer byte whose high bits are set checks that only the low bits are kept. An address that differs only in its lowest bit tests the address compare at its narrowest margin. The bench also covers combined write-then-read transfers, reads that resume from a pointer left by an earlier transfer, and a STOP in the middle of a byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;  // bus idles high
      else         ff_q <= {ff_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
  parameter int REG_AW = 3,
  localparam int DEPTH = 1 << REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic [REG_AW-1:0] ptr_addr_i,
  output logic [7:0]        ptr_rdata_o,
  input  logic              loc_we_i,
  input  logic [REG_AW-1:0] loc_addr_i,
  input  logic [7:0]        loc_wdata_i,
  output logic [7:0]        loc_rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (bus_we_i) begin
      mem_q[bus_addr_i] <= bus_wdata_i;
    end else if (loc_we_i) begin
      mem_q[loc_addr_i] <= loc_wdata_i;
    end
  end

  assign ptr_rdata_o = mem_q[ptr_addr_i];
  assign loc_rdata_o = mem_q[loc_addr_i];
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3C,
  parameter int         REG_AW   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [REG_AW-1:0] loc_addr_i,
  input  logic              loc_we_i,
  input  logic [7:0]        loc_wdata_i,
  output logic [7:0]        loc_rdata_o
);
  localparam logic [REG_AW-1:0] PTR_ONE = 1;

  logic       scl_s, sda_s;
  logic       start, stop, scl_rise, scl_fall;
  logic [7:0] ptr_rdata;

  tgt_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [7:0]        shr_q, tx_q;
  logic [REG_AW-1:0] ptr_q, wa_q;
  logic [7:0]        wd_q;
  logic              we_q, oe_q, rw_q, ptr_pend_q, nak_q;

  i2c_tgt_sync #(.N(2), .STAGES(2)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_s, sda_s})
  );

  i2c_tgt_cond cond_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  i2c_tgt_regfile #(.REG_AW(REG_AW)) rf_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (we_q),
    .bus_addr_i  (wa_q),
    .bus_wdata_i (wd_q),
    .ptr_addr_i  (ptr_q),
    .ptr_rdata_o (ptr_rdata),
    .loc_we_i    (loc_we_i),
    .loc_addr_i  (loc_addr_i),
    .loc_wdata_i (loc_wdata_i),
    .loc_rdata_o (loc_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shr_q      <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      wa_q       <= '0;
      wd_q       <= '0;
      we_q       <= 1'b0;
      oe_q       <= 1'b0;
      rw_q       <= 1'b0;
      ptr_pend_q <= 1'b0;
      nak_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (stop) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start) begin
        state_q    <= ST_ADDR;
        cnt_q      <= '0;
        oe_q       <= 1'b0;
        ptr_pend_q <= 1'b1;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shr_q <= {shr_q[6:0], sda_s};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              if (state_q == ST_ADDR) begin
                if (shr_q[7:1] == DEV_ADDR) begin
                  oe_q    <= 1'b1;
                  rw_q    <= shr_q[0];
                  state_q <= ST_AACK;
                end else begin
                  state_q <= ST_WAIT;
                end
              end else begin
                oe_q    <= 1'b1;
                state_q <= ST_WACK;
                if (ptr_pend_q) begin
                  ptr_q      <= shr_q[REG_AW-1:0];
                  ptr_pend_q <= 1'b0;
                end else begin
                  we_q  <= 1'b1;
                  wa_q  <= ptr_q;
                  wd_q  <= shr_q;
                  ptr_q <= ptr_q + PTR_ONE;
                end
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                tx_q    <= ptr_rdata;
                oe_q    <= ~ptr_rdata[7];
                cnt_q   <= 4'd1;
                ptr_q   <= ptr_q + PTR_ONE;
                state_q <= ST_RD;
              end else begin
                oe_q    <= 1'b0;
                cnt_q   <= '0;
                state_q <= ST_WR;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                oe_q  <= ~tx_q[6];
                tx_q  <= {tx_q[6:0], 1'b0};
                cnt_q <= cnt_q + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nak_q <= sda_s;
            end else if (scl_fall) begin
              if (nak_q) begin
                state_q <= ST_WAIT;
              end else begin
                tx_q    <= ptr_rdata;
                oe_q    <= ~ptr_rdata[7];
                cnt_q   <= 4'd1;
                ptr_q   <= ptr_q + PTR_ONE;
                state_q <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_o,
  input tgt_state_e        state_i,
  input logic              we_i,
  input logic [REG_AW-1:0] wa_i,
  input logic [REG_AW-1:0] ptr_i
);
  AST_OE_CHANGE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);  // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !sda_oe_o);  // R8
  AST_WAIT_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT) |-> !sda_oe_o);  // R7
  AST_CTRL_ACK_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RACK) |-> !sda_oe_o);  // R7
  AST_ADDR_ACK_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_AACK) |-> sda_oe_o);  // R2
  AST_WRITE_ADVANCES_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (ptr_i == REG_AW'(wa_i + 1'b1)));  // R4
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.REG_AW(REG_AW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .state_i  (state_q),
  .we_i     (we_q),
  .wa_i     (wa_q),
  .ptr_i    (ptr_q)
);

// File: tb/i2c_reg_target_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_target_tb_top;
  localparam logic [6:0] ADDR = 7'h3C;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [AW-1:0] loc_addr = '0;
  logic loc_we = 1'b0;
  logic [7:0] loc_wdata = '0;
  logic [7:0] loc_rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];
  int mp = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_target #(.DEV_ADDR(ADDR), .REG_AW(AW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .loc_addr_i  (loc_addr),
    .loc_we_i    (loc_we),
    .loc_wdata_i (loc_wdata),
    .loc_rdata_o (loc_rdata)
  );

  function automatic logic [7:0] exp_reg(int idx);
    return model[idx % DEPTH];
  endfunction

  function automatic int next_ptr(int p);
    return (p + 1) % DEPTH;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_bit(bit b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] v, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(bit give_ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic loc_read_all(string req);
    for (int i = 0; i < DEPTH; i++) begin
      loc_addr = AW'(i); tick(1);
      chk(loc_rdata == exp_reg(i), req, loc_rdata, exp_reg(i));
    end
  endtask

  // R3 R4: pointer byte then n data bytes
  task automatic bus_write(logic [7:0] pbyte, int n, logic [7:0] d [8]);
    bit ak;
    bus_start();
    send_byte({ADDR, 1'b0}, ak); chk(ak, "R2 addr ack", ak, 1);
    send_byte(pbyte, ak);        chk(ak, "R3 ptr ack", ak, 1);
    mp = pbyte % DEPTH;
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ak); chk(ak, "R4 data ack", ak, 1);
      model[mp] = d[i];
      mp = next_ptr(mp);
    end
    bus_stop();
  endtask

  // read n bytes from the current pointer, NAK on the last
  task automatic read_bytes(int n, string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      chk(v == exp_reg(mp), req, v, exp_reg(mp));
      mp = next_ptr(mp);
    end
  endtask

  // R6: pointer write, repeated START, read
  task automatic bus_combined(logic [7:0] pbyte, int n);
    bit ak;
    bus_start();
    send_byte({ADDR, 1'b0}, ak); chk(ak, "R2 addr ack", ak, 1);
    send_byte(pbyte, ak);        chk(ak, "R3 ptr ack", ak, 1);
    mp = pbyte % DEPTH;
    bus_start();
    send_byte({ADDR, 1'b1}, ak); chk(ak, "R6 addr ack after repeated start", ak, 1);
    read_bytes(n, "R5 R6 combined read");
    bus_stop();
  endtask

  task automatic bus_read_cur(int n, string req);
    bit ak;
    bus_start();
    send_byte({ADDR, 1'b1}, ak); chk(ak, "R2 read addr ack", ak, 1);
    read_bytes(n, req);
    bus_stop();
  endtask

  initial begin
    logic [7:0] d [8];
    logic [7:0] v;
    bit ak, b;
    void'($urandom(32'h1C2A_55AA));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    loc_read_all("R1 reset contents");
    bus_read_cur(1, "R1 pointer zero");

    // R3 R4 directed with wrap
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
    bus_write(8'h07, 3, d);
    loc_read_all("R4 wrap write");

    // R3 high pointer bits dropped
    d[0] = 8'h5E;
    bus_write(8'hF9, 1, d);
    loc_read_all("R3 pointer low bits");

    // R7 NAK releases, further clocks read high
    bus_combined(8'h00, 2);
    bus_start();
    send_byte({ADDR, 1'b1}, ak); chk(ak, "R2 read addr ack", ak, 1);
    recv_byte(1'b0, v);
    chk(v == exp_reg(mp), "R5 single read", v, exp_reg(mp));
    mp = next_ptr(mp);
    for (int i = 7; i >= 0; i--) begin
      get_bit(b); v[i] = b;
    end
    chk(v == 8'hFF, "R7 released after NAK", v, 8'hFF);
    bus_stop();
    chk(sda_oe == 1'b0, "R8 idle after stop", sda_oe, 0);

    // R2 wrong address: no ack, no write
    bus_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, ak); chk(!ak, "R2 mismatch nak", ak, 0);
    send_byte(8'h02, ak);                chk(!ak, "R2 mismatch data nak", ak, 0);
    send_byte(8'hC3, ak);                chk(!ak, "R2 mismatch data nak", ak, 0);
    bus_stop();
    loc_read_all("R2 mismatch no write");

    // R8 partial byte discarded
    bus_start();
    send_byte({ADDR, 1'b0}, ak); chk(ak, "R2 addr ack", ak, 1);
    send_byte(8'h02, ak);        chk(ak, "R3 ptr ack", ak, 1);
    mp = 2;
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    loc_read_all("R8 partial byte dropped");
    bus_read_cur(1, "R6 R8 pointer kept over stop");

    // R10 local write then bus read
    loc_addr = 3'd5; loc_wdata = 8'hA5; loc_we = 1'b1; tick(1);
    loc_we = 1'b0; model[5] = 8'hA5; tick(1);
    chk(loc_rdata == 8'hA5, "R10 local readback", loc_rdata, 8'hA5);
    bus_combined(8'h05, 1);

    // random traffic
    for (int r = 0; r < 12; r++) begin
      int n;
      logic [7:0] p;
      n = 1 + int'($urandom_range(0, 6));
      p = 8'($urandom);
      for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
      bus_write(p, n, d);
      bus_combined(8'($urandom), 1 + int'($urandom_range(0, 8)));
      bus_read_cur(1 + int'($urandom_range(0, 3)), "R5 R6 continued read");
    end
    loc_read_all("R4 random contents");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule